// File: doc/BRIEF.md
# NAND Subpage Hamming Check and Repair Unit

This unit finishes the read path of a NAND page protected by a Hamming code. Each 512-byte subpage comes with two 3-byte check values: the one written to the spare area at program time, and the one the data path computed while the page streamed into a byte buffer. The unit compares the two values for each subpage. It classifies the difference and, when exactly one data bit has flipped, repairs that bit in the buffer. It uses a read-modify-write on a byte port.

A start pulse launches one run. A mode input chooses whether only the first subpage or all four subpages of a 2048-byte page are handled. The check values are applied as flat vectors and are held steady until `done`. When the run ends, `done` pulses for one cycle. At that point `uncorrectable` and `corr_count` give the result, and they hold it until the next start.

Control is a five-state machine:
- `ST_IDLE` waits for `start`, then goes to `ST_EVAL`.
- `ST_EVAL` judges the current subpage in one cycle. A clean subpage moves on to the next subpage while staying in `ST_EVAL`, or goes to `ST_FINISH` after the last subpage. A correctable subpage goes to `ST_READ`. A failing subpage goes to `ST_FINISH`.
- `ST_READ` presents the faulty byte's address and always goes to `ST_WRITE`.
- `ST_WRITE` writes the repaired byte. It then returns to `ST_EVAL` for the next subpage, or goes to `ST_FINISH` after the last one.
- `ST_FINISH` raises `done` and always returns to `ST_IDLE`.

Top module: `hecc_corrector`

## Requirements
- R1: After reset, `done`, `uncorrectable` and `buf_we` are 0 and `corr_count` is 0.
- R2: A subpage whose stored and computed triplets are bit-identical is judged clean in one `ST_EVAL` cycle. No buffer write is made for it.
- R3: Each triplet is unpacked as follows. Byte 0 (bits 7:0) carries the even parities for weights 1..128. Byte 1 (bits 15:8) carries the odd parities for weights 1..128. The low nibble of byte 2 carries the even parities for weights 256..2048. The high nibble of byte 2 carries the odd parities for weights 256..2048.
- R4: When the XOR of the two triplets has exactly 12 ones, the error is correctable. The byte offset is taken from the odd-parity syndrome bits for weights 8 (LSB) up to 2048 (MSB). The bit index is taken from the odd bits for weights 1, 2 and 4. The unit reads address subpage*512+offset in `ST_READ`. In the next cycle it writes the read byte back with that bit inverted.
- R5: A syndrome with exactly 1 or exactly 11 ones is uncorrectable.
- R6: Any other nonzero syndrome is uncorrectable, except one case. If the stored triplet is 0xFFFFFF and the computed triplet is 0x000000, the subpage is erased and counts as clean.
- R7: With `quad_mode`=1, subpages 0..3 are handled in order. Triplet s sits at bits [24s+23:24s] of each ECC input. With `quad_mode`=0, only subpage 0 is handled and the other triplets have no effect.
- R8: The run stops at the first uncorrectable subpage. No later subpage is evaluated or written. `corr_count` then reports the repairs already made.
- R9: `corr_count` equals the number of bits repaired in the run, from 0 up to 4.
- R10: `done` is a one-cycle pulse in the cycle after the last evaluation. The last evaluation is the final `ST_EVAL` cycle, or the `ST_WRITE` cycle that ends a repair.
- R11: `start` clears `uncorrectable` and `corr_count`. Both are valid while `done` is high and hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a run (taken in `ST_IDLE` only) |
| quad_mode | input | 1 | 1: four subpages, 0: one subpage |
| stored_ecc | input | 96 | Spare-area triplets, subpage s at [24s+23:24s] |
| calc_ecc | input | 96 | Computed triplets, same layout |
| buf_rdata | input | 8 | Buffer read data, one cycle after the address |
| buf_addr | output | 11 | Buffer byte address |
| buf_wdata | output | 8 | Repaired byte |
| buf_we | output | 1 | Buffer write strobe |
| done | output | 1 | End-of-run pulse |
| uncorrectable | output | 1 | Run hit an uncorrectable subpage |
| corr_count | output | 3 | Bits repaired in the run |

## Verification
Timing is counted from the clock edge that samples `start`. The first `ST_EVAL` cycle follows that edge. Each clean or erased subpage takes one cycle, and each repaired subpage takes three cycles, with the write strobe in the third. `done`, `uncorrectable` and `corr_count` are due in the cycle after the last evaluation.

For every run, the bench builds a per-cycle queue of expected write strobe, address, write data and `done`. It pops one entry at each falling edge and compares it. After each run it also compares the whole buffer against its own model, so writes that skip a subpage or stray past a stop are caught.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
    localparam int SUB_BYTES = 512;
    localparam int OFF_W     = $clog2(SUB_BYTES);
    localparam int NPAIR     = OFF_W + 3;
    localparam int ECC_W     = 2 * NPAIR;
    localparam int POP_W     = $clog2(ECC_W + 1);

    typedef struct packed {
        logic [NPAIR-1:0] odd;
        logic [NPAIR-1:0] even;
    } parity_t;

    typedef enum logic [1:0] {
        VERD_CLEAN,
        VERD_FIX,
        VERD_FAIL
    } verdict_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } state_t;
endpackage

// File: rtl/hecc_unpack.sv
module hecc_unpack
    import hecc_pkg::*;
(
    input  logic [ECC_W-1:0] trip,
    output parity_t          par
);
    // byte 2 is split: low nibble to upper even weights, high nibble to upper odd weights
    always_comb begin
        par.even = {trip[19:16], trip[7:0]};
        par.odd  = {trip[23:20], trip[15:8]};
    end
endmodule

// File: rtl/hecc_classify.sv
module hecc_classify
    import hecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ECC_W-1:0] stored_trip,
    input  logic [ECC_W-1:0] calc_trip,
    input  parity_t          stored_par,
    input  parity_t          calc_par,
    output verdict_t         verdict,
    output logic [OFF_W-1:0] err_off,
    output logic [2:0]       err_bit
);
    parity_t          syn;
    logic [POP_W-1:0] pop;
    logic             same;
    logic             erased;

    always_comb begin
        syn    = stored_par ^ calc_par;
        pop    = POP_W'($countones(syn));
        same   = (stored_trip == calc_trip);
        erased = (stored_trip == {ECC_W{1'b1}}) && (calc_trip == '0);
        err_off = syn.odd[NPAIR-1:3];
        err_bit = syn.odd[2:0];
        if (same)
            verdict = VERD_CLEAN;
        else if (pop == POP_W'(NPAIR))
            verdict = VERD_FIX;
        else if (pop == POP_W'(1) || pop == POP_W'(NPAIR - 1))
            verdict = VERD_FAIL;
        else if (erased)
            verdict = VERD_CLEAN;
        else
            verdict = VERD_FAIL;
    end

    AST_FIX_NEEDS_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict == VERD_FIX) |-> (stored_trip != calc_trip)); // R4
    AST_CLEAN_DIFF_IS_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict == VERD_CLEAN && stored_trip != calc_trip) |->
        (stored_trip == {ECC_W{1'b1}} && calc_trip == '0)); // R6
endmodule

// File: rtl/hecc_corrector.sv
module hecc_corrector
    import hecc_pkg::*;
#(
    parameter  int MAX_SUB = 4,
    localparam int SUB_W   = $clog2(MAX_SUB),
    localparam int ADDR_W  = SUB_W + OFF_W,
    localparam int CNT_W   = $clog2(MAX_SUB + 1),
    localparam int VEC_W   = MAX_SUB * ECC_W
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              quad_mode,
    input  logic [VEC_W-1:0]  stored_ecc,
    input  logic [VEC_W-1:0]  calc_ecc,
    input  logic [7:0]        buf_rdata,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    output logic              buf_we,
    output logic              done,
    output logic              uncorrectable,
    output logic [CNT_W-1:0]  corr_count
);
    state_t             state_q, state_d;
    logic [SUB_W-1:0]   sub_q;
    logic               quad_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               unc_q;
    logic [OFF_W-1:0]   off_q;
    logic [2:0]         bit_q;
    logic               last_sub;

    logic [ECC_W-1:0]   st_arr [MAX_SUB];
    logic [ECC_W-1:0]   ca_arr [MAX_SUB];
    logic [ECC_W-1:0]   st_cur, ca_cur;
    parity_t            st_par, ca_par;
    verdict_t           verdict;
    logic [OFF_W-1:0]   err_off;
    logic [2:0]         err_bit;

    for (genvar s = 0; s < MAX_SUB; s++) begin : g_trip
        assign st_arr[s] = stored_ecc[s*ECC_W +: ECC_W];
        assign ca_arr[s] = calc_ecc[s*ECC_W +: ECC_W];
    end

    assign st_cur   = st_arr[sub_q];
    assign ca_cur   = ca_arr[sub_q];
    assign last_sub = quad_q ? (sub_q == SUB_W'(MAX_SUB - 1)) : 1'b1;

    hecc_unpack u_unpack_st (.trip(st_cur), .par(st_par));
    hecc_unpack u_unpack_ca (.trip(ca_cur), .par(ca_par));

    hecc_classify u_classify (
        .clk         (clk),
        .rst_n       (rst_n),
        .stored_trip (st_cur),
        .calc_trip   (ca_cur),
        .stored_par  (st_par),
        .calc_par    (ca_par),
        .verdict     (verdict),
        .err_off     (err_off),
        .err_bit     (err_bit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_EVAL;
            ST_EVAL: begin
                unique case (verdict)
                    VERD_CLEAN: if (last_sub) state_d = ST_FINISH;
                    VERD_FIX:   state_d = ST_READ;
                    VERD_FAIL:  state_d = ST_FINISH;
                    default:    state_d = ST_FINISH;
                endcase
            end
            ST_READ:   state_d = ST_WRITE;
            ST_WRITE:  state_d = last_sub ? ST_FINISH : ST_EVAL;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // run registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q  <= '0;
            quad_q <= 1'b0;
            cnt_q  <= '0;
            unc_q  <= 1'b0;
            off_q  <= '0;
            bit_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        quad_q <= quad_mode;
                        sub_q  <= '0;
                        cnt_q  <= '0;
                        unc_q  <= 1'b0;
                    end
                end
                ST_EVAL: begin
                    unique case (verdict)
                        VERD_CLEAN: if (!last_sub) sub_q <= sub_q + SUB_W'(1);
                        VERD_FIX: begin
                            off_q <= err_off;
                            bit_q <= err_bit;
                        end
                        VERD_FAIL: unc_q <= 1'b1;
                        default:   unc_q <= 1'b1;
                    endcase
                end
                ST_WRITE: begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (!last_sub) sub_q <= sub_q + SUB_W'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        buf_addr      = {sub_q, off_q};
        buf_we        = (state_q == ST_WRITE);
        buf_wdata     = (state_q == ST_WRITE) ? (buf_rdata ^ (8'd1 << bit_q)) : 8'd0;
        done          = (state_q == ST_FINISH);
        uncorrectable = unc_q;
        corr_count    = cnt_q;
    end

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> ($past(state_q) == ST_READ)); // R4
    AST_WRITE_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> $stable(buf_addr)); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        corr_count <= CNT_W'(MAX_SUB)); // R9
    AST_FAIL_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uncorrectable) |-> (state_q == ST_FINISH)); // R8
    AST_SINGLE_STAYS_SUB0: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !quad_q) |-> (sub_q == '0)); // R7
endmodule

// File: tb/hecc_corrector_tb.sv
`timescale 1ns/1ps
module hecc_corrector_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        quad_mode = 1'b0;
    logic [95:0] stored_ecc = '0;
    logic [95:0] calc_ecc = '0;
    logic [7:0]  buf_rdata = '0;
    logic [10:0] buf_addr;
    logic [7:0]  buf_wdata;
    logic        buf_we;
    logic        done;
    logic        uncorrectable;
    logic [2:0]  corr_count;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    logic [7:0] mem   [0:2047];
    logic [7:0] model [0:2047];

    always #2.5 clk = ~clk;

    hecc_corrector u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .quad_mode(quad_mode),
        .stored_ecc(stored_ecc), .calc_ecc(calc_ecc), .buf_rdata(buf_rdata),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_we(buf_we),
        .done(done), .uncorrectable(uncorrectable), .corr_count(corr_count)
    );

    // page buffer: one-cycle read latency, read-before-write
    always @(posedge clk) begin
        buf_rdata <= mem[buf_addr];
        if (buf_we) mem[buf_addr] <= buf_wdata;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            nerr = nerr + 1;
            $display("FAIL watchdog act=%0d exp=<100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk = nchk + 1;
        if (!ok) begin
            nerr = nerr + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // R3 layout: byte0 even 1..128, byte1 odd 1..128, byte2 {odd 256..2048, even 256..2048}
    function automatic logic [23:0] pack_syn(input logic [11:0] ev, input logic [11:0] od);
        return {od[11:8], ev[11:8], od[7:0], ev[7:0]};
    endfunction

    function automatic logic [23:0] one_err(input int off, input int bi);
        logic [11:0] od;
        od = {off[8:0], bi[2:0]};
        return pack_syn(~od, od);
    endfunction

    task automatic mem_compare(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < 2048; i++)
            if (mem[i] !== model[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        chk(bad == 0, req, first, -1);
    endtask

    task automatic run_op(input bit quad, input logic [95:0] st, input logic [95:0] ca,
                          input string tag);
        int qwe[$];
        int qaddr[$];
        int qwd[$];
        int expcnt = 0;
        bit expunc = 0;
        int ns = quad ? 4 : 1;
        for (int s = 0; s < ns; s++) begin
            logic [23:0] a, b, x;
            logic [11:0] od;
            int pc, off, bi, addr;
            a = st[24*s +: 24];
            b = ca[24*s +: 24];
            x = a ^ b;
            pc = $countones(x);
            if (x == 0 || (pc != 12 && pc != 1 && pc != 11 && a == 24'hFFFFFF && b == 0)) begin
                qwe.push_back(0); qaddr.push_back(0); qwd.push_back(0);
            end else if (pc == 12) begin
                od = {x[23:20], x[15:8]};
                off = int'(od[11:3]);
                bi = int'(od[2:0]);
                addr = s * 512 + off;
                qwe.push_back(0); qaddr.push_back(0); qwd.push_back(0);
                qwe.push_back(0); qaddr.push_back(0); qwd.push_back(0);
                qwe.push_back(1); qaddr.push_back(addr);
                qwd.push_back(int'(model[addr] ^ (8'd1 << bi)));
                model[addr] = model[addr] ^ (8'd1 << bi);
                expcnt++;
            end else begin
                qwe.push_back(0); qaddr.push_back(0); qwd.push_back(0);
                expunc = 1;
                break;
            end
        end
        qwe.push_back(0); qaddr.push_back(0); qwd.push_back(0);

        @(negedge clk);
        quad_mode = quad; stored_ecc = st; calc_ecc = ca; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < qwe.size(); i++) begin
            if (i > 0) @(negedge clk);
            chk(buf_we == qwe[i][0], tag, buf_we, qwe[i]);
            if (qwe[i] == 1) begin
                chk(int'(buf_addr) == qaddr[i], tag, buf_addr, qaddr[i]);
                chk(int'(buf_wdata) == qwd[i], tag, buf_wdata, qwd[i]);
            end
            chk(done == (i == qwe.size() - 1), "R10", done, (i == qwe.size() - 1));
        end
        chk(uncorrectable == expunc, tag, uncorrectable, expunc);
        chk(int'(corr_count) == expcnt, tag, corr_count, expcnt);
        @(negedge clk);
        chk(done == 1'b0, "R10", done, 0);
        chk(uncorrectable == expunc && int'(corr_count) == expcnt, "R11",
            {uncorrectable, corr_count}, {expunc, expcnt[2:0]});
        mem_compare(tag);
    endtask

    localparam logic [23:0] C0 = 24'h3C5A96;
    localparam logic [23:0] C1 = 24'h81F00E;
    localparam logic [23:0] C2 = 24'h12AB34;
    localparam logic [23:0] C3 = 24'hE7D219;

    initial begin
        logic [95:0] base;
        base = {C3, C2, C1, C0};
        for (int i = 0; i < 2048; i++) begin
            mem[i]   = 8'(i * 7 + 3);
            model[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(done == 0 && uncorrectable == 0 && corr_count == 0 && buf_we == 0, "R1",
            {done, uncorrectable, corr_count, buf_we}, 0);

        // R2 identical triplets
        run_op(1'b0, base, base, "R2");
        run_op(1'b1, base, base, "R2");

        // R4 single-bit repair in subpage 0
        run_op(1'b0, base ^ {72'd0, one_err(9'h1A5, 6)}, base, "R4");

        // R3 boundary offsets reaching the byte-2 nibbles, subpages 1 and 3
        run_op(1'b1, base ^ {one_err(511, 7), 24'd0, one_err(0, 0), 24'd0}, base, "R3");

        // R9 four repairs
        run_op(1'b1, base ^ {one_err(9'h1C3, 5), one_err(9'h0FF, 3),
                             one_err(9'h100, 2), one_err(9'h055, 1)}, base, "R9");

        // R5 popcount 1, then R11 clean run clears the flag
        run_op(1'b0, base ^ {72'd0, pack_syn(12'h001, 12'h000)}, base, "R5");
        run_op(1'b0, base, base, "R11");
        // R5 popcount 11
        run_op(1'b0, base ^ {72'd0, pack_syn(12'hF0E, 12'h0F0)}, base, "R5");

        // R6 erased page is clean; near-erased and popcount 5 fail
        run_op(1'b1, {96{1'b1}}, 96'd0, "R6");
        run_op(1'b0, {72'd0, 24'hFFFFFF}, {72'd0, 24'h000001}, "R6");
        run_op(1'b0, base ^ {72'd0, pack_syn(12'h000, 12'h01F)}, base, "R6");

        // R8 stop at first failure: subpage 2 must stay untouched
        run_op(1'b1, base ^ {24'd0, one_err(9'h033, 4), pack_syn(12'h001, 12'h000),
                             one_err(9'h0AA, 2)}, base, "R8");

        // R7 single mode ignores failing triplets in subpages 1..3
        run_op(1'b0, base ^ {pack_syn(12'h001, 12'h0), pack_syn(12'h0, 12'h01F),
                             pack_syn(12'hF0E, 12'h0F0), one_err(9'h144, 3)}, base, "R7");

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule